// File: doc/BRIEF.md
# Swappable Boot Memory Chip-Select Decoder

This block sits beside a microcontroller whose low sixteen address bits share pins with the data on a multiplexed bus. It captures the address when the address-latch strobe ends. It compares the full 24-bit address against a set of fixed windows. It then drives one active-high select for each of the following targets: the lower boot-flash half, the upper boot-flash half, a main-flash sector, an SRAM, a character-display window and a small register window.

The register window contains an 8-bit page register that the processor can write and read over the same bus. Bit 6 of this register is the swap control. While the bit is clear, the boot flash answers in the execution range at the bottom of the map, and the main-flash sector sits in the second 64 KiB segment. Once the bit is set, the main-flash sector takes over the execution range and the boot flash disappears from the map. Firmware uses this to hand execution from a boot image to a main image in a single register write. Because the register clears on reset, every start begins in the boot flash.

Top module: `swap_cs_decoder`

## Requirements
- R1: While page bit 6 is 0, `csBoot0` is high exactly for latched addresses 0x00000–0x01FFF.
- R2: While page bit 6 is 0, `csBoot1` is high exactly for latched addresses 0x02000–0x03FFF.
- R3: While page bit 6 is 0, `csMain` is high exactly for latched addresses 0x10000–0x1FFFF.
- R4: While page bit 6 is 1, `csMain` is high exactly for 0x00000–0x03FFF, is low for 0x10000–0x1FFFF, and neither boot select asserts for any address.
- R5: The page register sits at address 0x0BF10 and is 0x00 after reset. Bit 6 is the only bit that affects decoding. A write to any other offset in the register window leaves it unchanged.
- R6: A page write takes effect when `wrN` rises while the latched address is 0x0BF10. The register then takes `adIn[7:0]`. The next bus cycle decodes with the new value, with no wait cycle. A write while another window is latched is ignored.
- R7: `csSram` is high exactly for 0x08000–0x09FFF, whatever the page value.
- R8: `csLcd` is high exactly for 0x0BE00–0x0BEFF, and `csRegs` is high exactly for 0x0BF00–0x0BFFF.
- R9: The address is captured on the falling edge of `ale`. Bits 15:0 come from `adIn` and bits 23:16 come from `addrHi`. Changes on `adIn` after that edge do not alter the decode.
- R10: At most one select is high at any time. No select is high for an unmapped address, while `rstN` is low, or after reset before the first address capture.
- R11: While `rdN` is low and 0x0BF10 is latched, `adOe` is 1 and `adOut` equals {8'h00, page}. Otherwise `adOe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock used to sample all bus strobes |
| rstN | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address latch strobe; the address is captured on its falling edge |
| adIn | input | 16 | Multiplexed address/data bus, input side |
| addrHi | input | 8 | Non-multiplexed address bits 23:16 |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe; a page write commits on its rising edge |
| adOut | output | 16 | Read data from the page register |
| adOe | output | 1 | High while the block drives read data |
| csBoot0 | output | 1 | Lower boot-flash half select |
| csBoot1 | output | 1 | Upper boot-flash half select |
| csMain | output | 1 | Main-flash sector select |
| csSram | output | 1 | SRAM select |
| csLcd | output | 1 | Display window select |
| csRegs | output | 1 | Register window select |

## Verification
Two functions can fall on the same edge. One is the page write that retires as `wrN` rises. The other is the decode that the next bus cycle relies on, because the register window stays latched while the swap bit flips underneath it. The bench provokes this by writing the swap bit and then issuing the very next address capture at 0x00000. It judges the result by whether `csMain`, and not a boot select, is high on that first cycle. It also reads the register back right away and confirms that the register select held through the write.

// File: rtl/swap_cs_pkg.sv
package swap_cs_pkg;

  // strobes from the bus sequencer to the datapath
  typedef struct packed {
    logic latchAddr;   // ale falling edge seen this cycle
    logic pageWrite;   // wrN rising edge seen this cycle
  } busStrobe_t;

  localparam int SEL_N = 6;
  localparam int SEL_BOOT0 = 5;
  localparam int SEL_BOOT1 = 4;
  localparam int SEL_MAIN  = 3;
  localparam int SEL_SRAM  = 2;
  localparam int SEL_LCD   = 1;
  localparam int SEL_REGS  = 0;

  // fixed windows, inclusive bounds, 24-bit map
  localparam logic [23:0] BOOT0_LO = 24'h000000, BOOT0_HI = 24'h001FFF;
  localparam logic [23:0] BOOT1_LO = 24'h002000, BOOT1_HI = 24'h003FFF;
  localparam logic [23:0] EXEC_LO  = 24'h000000, EXEC_HI  = 24'h003FFF;
  localparam logic [23:0] MAINU_LO = 24'h010000, MAINU_HI = 24'h01FFFF;
  localparam logic [23:0] SRAM_LO  = 24'h008000, SRAM_HI  = 24'h009FFF;
  localparam logic [23:0] LCD_LO   = 24'h00BE00, LCD_HI   = 24'h00BEFF;
  localparam logic [23:0] REGS_LO  = 24'h00BF00, REGS_HI  = 24'h00BFFF;

endpackage

// File: rtl/swap_bus_ctrl.sv
module swap_bus_ctrl
  import swap_cs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ale,
  input  logic       wrN,
  output busStrobe_t strobe
);

  logic aleQ;
  logic wrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aleQ <= 1'b0;
      wrQ  <= 1'b1;
    end else begin
      aleQ <= ale;
      wrQ  <= wrN;
    end
  end

  always_comb begin
    strobe.latchAddr = aleQ && !ale;
    strobe.pageWrite = !wrQ && wrN;
  end

endmodule

// File: rtl/swap_datapath.sv
module swap_datapath
  import swap_cs_pkg::*;
#(
  parameter int LOW_W    = 16,
  parameter int HIGH_W   = 8,
  parameter int PAGE_W   = 8,
  parameter int SWAP_BIT = 6,
  parameter int OFS_W    = 8,
  parameter logic [OFS_W-1:0] PAGE_OFS = 8'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [LOW_W-1:0]  adIn,
  input  logic [HIGH_W-1:0] addrHi,
  input  logic              rdN,
  output logic [LOW_W-1:0]  adOut,
  output logic              adOe,
  output logic [SEL_N-1:0]  selVec
);

  localparam int ADDR_W = LOW_W + HIGH_W;

  logic [ADDR_W-1:0] addrQ;
  logic              addrValid;
  logic [PAGE_W-1:0] pageQ;
  logic [23:0]       addrExt;
  logic              swapOn;
  logic              pageHit;

  function automatic logic inRange(input logic [23:0] a,
                                   input logic [23:0] lo,
                                   input logic [23:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // address capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      addrValid <= 1'b0;
    end else if (strobe.latchAddr) begin
      addrQ     <= {addrHi, adIn};
      addrValid <= 1'b1;
    end
  end

  assign addrExt = 24'(addrQ);
  assign swapOn  = pageQ[SWAP_BIT];
  assign pageHit = addrValid && inRange(addrExt, REGS_LO, REGS_HI)
                   && (addrQ[OFS_W-1:0] == PAGE_OFS);

  // page register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pageQ <= '0;
    else if (strobe.pageWrite && pageHit)
      pageQ <= adIn[PAGE_W-1:0];
  end

  // window decode
  always_comb begin
    selVec = '0;
    if (addrValid) begin
      selVec[SEL_BOOT0] = !swapOn && inRange(addrExt, BOOT0_LO, BOOT0_HI);
      selVec[SEL_BOOT1] = !swapOn && inRange(addrExt, BOOT1_LO, BOOT1_HI);
      selVec[SEL_MAIN]  = swapOn ? inRange(addrExt, EXEC_LO, EXEC_HI)
                                 : inRange(addrExt, MAINU_LO, MAINU_HI);
      selVec[SEL_SRAM]  = inRange(addrExt, SRAM_LO, SRAM_HI);
      selVec[SEL_LCD]   = inRange(addrExt, LCD_LO, LCD_HI);
      selVec[SEL_REGS]  = inRange(addrExt, REGS_LO, REGS_HI);
    end
  end

  // read return
  always_comb begin
    adOe  = pageHit && !rdN;
    adOut = adOe ? LOW_W'(pageQ) : '0;
  end

endmodule

// File: rtl/swap_cs_decoder.sv
module swap_cs_decoder
  import swap_cs_pkg::*;
#(
  parameter int LOW_W    = 16,
  parameter int HIGH_W   = 8,
  parameter int PAGE_W   = 8,
  parameter int SWAP_BIT = 6,
  parameter int OFS_W    = 8,
  parameter logic [OFS_W-1:0] PAGE_OFS = 8'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ale,
  input  logic [LOW_W-1:0]  adIn,
  input  logic [HIGH_W-1:0] addrHi,
  input  logic              rdN,
  input  logic              wrN,
  output logic [LOW_W-1:0]  adOut,
  output logic              adOe,
  output logic              csBoot0,
  output logic              csBoot1,
  output logic              csMain,
  output logic              csSram,
  output logic              csLcd,
  output logic              csRegs
);

  busStrobe_t       strobe;
  logic [SEL_N-1:0] selVec;

  swap_bus_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .ale    (ale),
    .wrN    (wrN),
    .strobe (strobe)
  );

  swap_datapath #(
    .LOW_W    (LOW_W),
    .HIGH_W   (HIGH_W),
    .PAGE_W   (PAGE_W),
    .SWAP_BIT (SWAP_BIT),
    .OFS_W    (OFS_W),
    .PAGE_OFS (PAGE_OFS)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .adIn   (adIn),
    .addrHi (addrHi),
    .rdN    (rdN),
    .adOut  (adOut),
    .adOe   (adOe),
    .selVec (selVec)
  );

  assign csBoot0 = selVec[SEL_BOOT0];
  assign csBoot1 = selVec[SEL_BOOT1];
  assign csMain  = selVec[SEL_MAIN];
  assign csSram  = selVec[SEL_SRAM];
  assign csLcd   = selVec[SEL_LCD];
  assign csRegs  = selVec[SEL_REGS];

endmodule

// File: rtl/swap_cs_checker.sv
module swap_cs_checker (
  input logic        clk,
  input logic        rstN,
  input logic        ale,
  input logic [15:0] adIn,
  input logic [7:0]  addrHi,
  input logic        rdN,
  input logic [15:0] adOut,
  input logic        adOe,
  input logic        csBoot0,
  input logic        csBoot1,
  input logic        csMain,
  input logic        csSram,
  input logic        csLcd,
  input logic        csRegs
);

  logic        aleSeen;
  logic [23:0] obsAddr;
  logic [5:0]  allSel;

  // observed bus address, captured independently at the ports
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aleSeen <= 1'b0;
      obsAddr <= '0;
    end else begin
      aleSeen <= ale;
      if (aleSeen && !ale) obsAddr <= {addrHi, adIn};
    end
  end

  assign allSel = {csBoot0, csBoot1, csMain, csSram, csLcd, csRegs};

  assert_sel_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(allSel));

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rstN |-> (allSel == 6'b0) && !adOe);

  assert_boot0_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    csBoot0 |-> obsAddr <= 24'h001FFF);

  assert_boot1_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    csBoot1 |-> (obsAddr >= 24'h002000) && (obsAddr <= 24'h003FFF));

  assert_main_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    csMain |-> (obsAddr <= 24'h003FFF) ||
               ((obsAddr >= 24'h010000) && (obsAddr <= 24'h01FFFF)));

  assert_sram_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    csSram |-> (obsAddr >= 24'h008000) && (obsAddr <= 24'h009FFF));

  assert_read_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> csRegs && !rdN && (adOut[15:8] == 8'h00));

endmodule

bind swap_cs_decoder swap_cs_checker i_checker (
  .clk     (clk),
  .rstN    (rstN),
  .ale     (ale),
  .adIn    (adIn),
  .addrHi  (addrHi),
  .rdN     (rdN),
  .adOut   (adOut),
  .adOe    (adOe),
  .csBoot0 (csBoot0),
  .csBoot1 (csBoot1),
  .csMain  (csMain),
  .csSram  (csSram),
  .csLcd   (csLcd),
  .csRegs  (csRegs)
);

// File: tb/test_swap_cs_decoder.sv
module test_swap_cs_decoder;

  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] PAGE_ADDR = 24'h00BF10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ale = 1'b0;
  logic [15:0] adIn = '0;
  logic [7:0]  addrHi = '0;
  logic        rdN = 1'b1;
  logic        wrN = 1'b1;
  logic [15:0] adOut;
  logic        adOe;
  logic        csBoot0, csBoot1, csMain, csSram, csLcd, csRegs;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swap_cs_decoder i_swap_cs_decoder (
    .clk(clk), .rstN(rstN), .ale(ale), .adIn(adIn), .addrHi(addrHi),
    .rdN(rdN), .wrN(wrN), .adOut(adOut), .adOe(adOe),
    .csBoot0(csBoot0), .csBoot1(csBoot1), .csMain(csMain),
    .csSram(csSram), .csLcd(csLcd), .csRegs(csRegs)
  );

  function automatic logic [5:0] expectSel(input logic [23:0] a, input logic sw);
    logic [5:0] e;
    e = '0;
    e[5] = !sw && a <= 24'h001FFF;
    e[4] = !sw && a >= 24'h002000 && a <= 24'h003FFF;
    e[3] = sw ? (a <= 24'h003FFF) : (a >= 24'h010000 && a <= 24'h01FFFF);
    e[2] = a >= 24'h008000 && a <= 24'h009FFF;
    e[1] = a >= 24'h00BE00 && a <= 24'h00BEFF;
    e[0] = a >= 24'h00BF00 && a <= 24'h00BFFF;
    return e;
  endfunction

  function automatic logic [5:0] gotSel();
    return {csBoot0, csBoot1, csMain, csSram, csLcd, csRegs};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // address phase; adIn is scrambled after ale falls (R9)
  task automatic busAddr(input logic [23:0] a);
    @(negedge clk);
    ale = 1'b1; adIn = a[15:0]; addrHi = a[23:16];
    @(negedge clk);
    ale = 1'b0;
    @(negedge clk);
    adIn = ~a[15:0]; addrHi = ~a[23:16];
  endtask

  task automatic checkMap(input string req, input logic [23:0] a, input logic sw);
    busAddr(a);
    @(negedge clk);
    check(req, {26'b0, gotSel()}, {26'b0, expectSel(a, sw)});
  endtask

  task automatic writeAt(input logic [23:0] a, input logic [7:0] d);
    busAddr(a);
    @(negedge clk);
    adIn = {8'h00, d}; wrN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wrN = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic readPage(input string req, input logic [7:0] exp);
    busAddr(PAGE_ADDR);
    @(negedge clk);
    rdN = 1'b0;
    #1;
    check(req, {31'b0, adOe}, 32'd1);
    check(req, {16'b0, adOut}, {24'b0, exp});
    @(negedge clk);
    rdN = 1'b1;
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset quiet", {25'b0, gotSel(), adOe}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 no select before first capture", {26'b0, gotSel()}, 32'd0);
    readPage("R5 page reset 0x00", 8'h00);
  endtask

  task automatic t_bootMap();
    checkMap("R1 boot0 low", 24'h000000, 1'b0);
    checkMap("R1 boot0 high", 24'h001FFF, 1'b0);
    checkMap("R2 boot1 low", 24'h002000, 1'b0);
    checkMap("R2 boot1 high", 24'h003FFF, 1'b0);
    checkMap("R3 main upper low", 24'h010000, 1'b0);
    checkMap("R3 main upper high", 24'h01FFFF, 1'b0);
    checkMap("R10 unmapped 0x04000", 24'h004000, 1'b0);
    checkMap("R10 unmapped 0x20000", 24'h020000, 1'b0);
    checkMap("R9 high byte from addrHi", 24'h01BE00, 1'b0);
  endtask

  task automatic t_fixedWindows(input logic sw);
    checkMap("R7 sram low", 24'h008000, sw);
    checkMap("R7 sram high", 24'h009FFF, sw);
    checkMap("R10 unmapped 0x0A000", 24'h00A000, sw);
    checkMap("R8 lcd low", 24'h00BE00, sw);
    checkMap("R8 lcd high", 24'h00BEFF, sw);
    checkMap("R8 regs low", 24'h00BF00, sw);
    checkMap("R8 regs high", 24'h00BFFF, sw);
  endtask

  task automatic t_swap();
    writeAt(PAGE_ADDR, 8'h40);
    check("R6 regs held through write", {31'b0, csRegs}, 32'd1);
    checkMap("R6 R4 first cycle after swap", 24'h000000, 1'b1);
    readPage("R11 readback 0x40", 8'h40);
    checkMap("R4 main exec high", 24'h003FFF, 1'b1);
    checkMap("R4 main exec mid", 24'h002000, 1'b1);
    checkMap("R4 upper window gone", 24'h010000, 1'b1);
    checkMap("R4 unmapped 0x04000", 24'h004000, 1'b1);
  endtask

  task automatic t_ignored();
    writeAt(24'h00BF11, 8'h00);
    readPage("R5 other offset ignored", 8'h40);
    writeAt(24'h008000, 8'h00);
    readPage("R6 write to sram window ignored", 8'h40);
    busAddr(24'h008000);
    @(negedge clk);
    rdN = 1'b0;
    #1;
    check("R11 no drive outside page", {31'b0, adOe}, 32'd0);
    @(negedge clk);
    rdN = 1'b1;
  endtask

  task automatic t_unswap();
    writeAt(PAGE_ADDR, 8'hBF);
    checkMap("R5 only bit6 matters boot0", 24'h000100, 1'b0);
    checkMap("R2 boot1 after unswap", 24'h003000, 1'b0);
    readPage("R11 readback 0xBF", 8'hBF);
  endtask

  initial begin
    t_reset();
    t_bootMap();
    t_fixedWindows(1'b0);
    t_swap();
    t_fixedWindows(1'b1);
    t_ignored();
    t_unswap();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule